// File: doc/BRIEF.md
# Receive Interrupt Status and Masking

This block collects the receive-side interrupt causes of an audio serial receiver and presents them as raw status and masked status. It also drives one interrupt line. The first cause is a FIFO service request. It follows a comparison of the current FIFO fill level against a programmable limit, and it is gated by two mask bits. The second cause is a read error. It is latched whenever the consumer reads an empty FIFO or reads the two halves of a stereo pair out of order. The error stays latched until a write-1-to-clear pulse removes it.

The FIFO level counts sample slots from 0 to 16. The limit is a 5-bit value, so any limit of 16 or above can never produce a service request. Interrupts from other parts of the chip, such as the transmit side, arrive on one input that is ORed straight into the interrupt line.

Top module: `rx_irq_ctrl`

## Requirements
- R1: `raw_o[0]` (service request) is 1 exactly when `sreq_gate_i` is 1 and `level_i` is strictly greater than `limit_i`. It follows its inputs combinationally and is not sticky.
- R2: `masked_o[0]` equals `raw_o[0]` ANDed with `sreq_mask_i`.
- R3: When any bit of `err_evt_i` is 1 at a rising clock edge, `raw_o[1]` (read error) is 1 after that edge. Bit 0 of `err_evt_i` is the empty-read event and bit 1 is the out-of-order stereo event.
- R4: Once set, `raw_o[1]` stays 1 while `err_clr_i` is 0. A clock edge with `err_clr_i` at 1 and no event clears it, and the masked error bit goes low with it.
- R5: When an error event and `err_clr_i` are both 1 at the same edge, `raw_o[1]` is 1 after that edge.
- R6: `masked_o[1]` equals `raw_o[1]` ANDed with `err_mask_i`.
- R7: `irq_o` is 1 exactly when either bit of `masked_o` is 1 or `other_irq_i` is 1.
- R8: A limit of 16 or more never raises `raw_o[0]`, even at a full level of 16.
- R9: After reset `raw_o[1]` is 0. With all inputs at 0, `raw_o`, `masked_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 5 | Receive FIFO fill level, 0 to 16 |
| limit_i | input | 5 | Service request limit |
| sreq_mask_i | input | 1 | Primary enable of the service request |
| sreq_gate_i | input | 1 | Second-level enable of the service request |
| err_mask_i | input | 1 | Enable of the read error |
| err_evt_i | input | 2 | Error event pulses: [0] empty read, [1] stereo order |
| err_clr_i | input | 1 | Write-1-to-clear pulse for the error status |
| other_irq_i | input | 1 | Other interrupt sources, ORed into irq_o |
| raw_o | output | 2 | Raw status: [0] service request, [1] read error |
| masked_o | output | 2 | Masked status, same bit order |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The comparator is tried with a level above the limit, equal to it and below it. These cases separate a strict comparison from an inclusive or off-by-one one. The full level is tried against limits of 15, 16 and 31, which shows where the limit saturates. The two service masks are switched off one at a time, which shows that raw status depends only on the second-level gate and masked status depends on both. Each error event bit is applied on its own, then a clear is applied alone and a clear together with an event, which separates the sticky, clear and collision behaviour. The external source is raised while all local sources are idle.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam int unsigned SRC_SREQ = 0;
  localparam int unsigned SRC_ERR  = 1;
  localparam int unsigned N_SRC    = 2;
  typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rx_lvl_cmp.sv
module rx_lvl_cmp #(
  parameter int unsigned LVL_W = 5
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] limit_i,
  input  logic             gate_i,
  output logic             req_o
);
  // strict compare; level never exceeds depth, so limit >= depth is inert
  assign req_o = gate_i && (level_i > limit_i);
endmodule

// File: rtl/rx_err_sticky.sv
module rx_err_sticky #(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic any_evt;
  assign any_evt = |evt_i;

  // new event takes priority over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (any_evt) flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/rx_irq_combine.sv
module rx_irq_combine #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] raw_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             ext_i,
  output logic [N_SRC-1:0] masked_o,
  output logic             irq_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_mask
    assign masked_o[g] = raw_i[g] & mask_i[g];
  end
  assign irq_o = (|masked_o) | ext_i;
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned N_EVT      = 2,
  localparam int unsigned LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] limit_i,
  input  logic             sreq_mask_i,
  input  logic             sreq_gate_i,
  input  logic             err_mask_i,
  input  logic [N_EVT-1:0] err_evt_i,
  input  logic             err_clr_i,
  input  logic             other_irq_i,
  output logic [N_SRC-1:0] raw_o,
  output logic [N_SRC-1:0] masked_o,
  output logic             irq_o
);
  src_vec_t raw, mask;

  rx_lvl_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i (level_i),
    .limit_i (limit_i),
    .gate_i  (sreq_gate_i),
    .req_o   (raw[SRC_SREQ])
  );

  rx_err_sticky #(.N_EVT(N_EVT)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt_i),
    .clr_i  (err_clr_i),
    .flag_o (raw[SRC_ERR])
  );

  always_comb begin
    mask           = '0;
    mask[SRC_SREQ] = sreq_mask_i;
    mask[SRC_ERR]  = err_mask_i;
  end

  rx_irq_combine #(.N_SRC(N_SRC)) u_comb (
    .raw_i    (raw),
    .mask_i   (mask),
    .ext_i    (other_irq_i),
    .masked_o (masked_o),
    .irq_o    (irq_o)
  );

  assign raw_o = raw;
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned N_EVT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] level_i,
  input logic [LVL_W-1:0] limit_i,
  input logic             sreq_mask_i,
  input logic             sreq_gate_i,
  input logic             err_mask_i,
  input logic [N_EVT-1:0] err_evt_i,
  input logic             err_clr_i,
  input logic             other_irq_i,
  input logic [1:0]       raw_o,
  input logic [1:0]       masked_o,
  input logic             irq_o
);
  p_sreq_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[0] |-> (sreq_gate_i && level_i > limit_i));
  p_smask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o[0] |-> (raw_o[0] && sreq_mask_i));
  p_err_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_evt_i) |=> raw_o[1]);
  p_err_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_o[1]) |-> $past(|err_evt_i));
  p_err_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[1] && !err_clr_i) |=> raw_o[1]);
  p_err_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !(|err_evt_i)) |=> !raw_o[1]);
  p_emask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o[1] |-> (raw_o[1] && err_mask_i));
  p_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((|masked_o) || other_irq_i));
  p_limit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i >= 5'd16) |-> !raw_o[0]);
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk #(.LVL_W(LVL_W), .N_EVT(N_EVT)) u_chk (.*);

// File: tb/rx_irq_ctrl_test.sv
module rx_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] level = '0, limit = '0;
  logic       smask = 1'b0, sgate = 1'b0, emask = 1'b0, eclr = 1'b0, ext = 1'b0;
  logic [1:0] evt = '0;
  logic [1:0] raw, msk;
  logic       irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .level_i(level), .limit_i(limit),
    .sreq_mask_i(smask), .sreq_gate_i(sgate), .err_mask_i(emask),
    .err_evt_i(evt), .err_clr_i(eclr), .other_irq_i(ext),
    .raw_o(raw), .masked_o(msk), .irq_o(irq)
  );

  // {level, limit, gate, mask, ext, exp_raw0, exp_msk0, exp_irq}
  localparam logic [15:0] VEC [10] = '{
    {5'd5,  5'd4,  1'b1, 1'b1, 1'b0, 3'b111},
    {5'd4,  5'd4,  1'b1, 1'b1, 1'b0, 3'b000},
    {5'd0,  5'd0,  1'b1, 1'b1, 1'b0, 3'b000},
    {5'd16, 5'd15, 1'b1, 1'b1, 1'b0, 3'b111},
    {5'd16, 5'd16, 1'b1, 1'b1, 1'b0, 3'b000},
    {5'd10, 5'd3,  1'b0, 1'b1, 1'b0, 3'b000},
    {5'd10, 5'd3,  1'b1, 1'b0, 1'b0, 3'b100},
    {5'd1,  5'd0,  1'b1, 1'b1, 1'b0, 3'b111},
    {5'd0,  5'd16, 1'b1, 1'b1, 1'b1, 3'b001},
    {5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 raw in reset", 32'(raw), 0);
    rst_n = 1'b1;
    step();
    chk("R9 raw after reset", 32'(raw), 0);
    chk("R9 masked after reset", 32'(msk), 0);
    chk("R9 irq after reset", 32'(irq), 0);

    // service request table, error idle (R1 R2 R7 R8)
    for (int i = 0; i < 10; i++) begin
      {level, limit, sgate, smask, ext} = VEC[i][15:3];
      #1;
      chk($sformatf("R1 raw0 vec%0d", i), 32'(raw[0]), 32'(VEC[i][2]));
      chk($sformatf("R2 msk0 vec%0d", i), 32'(msk[0]), 32'(VEC[i][1]));
      chk($sformatf("R7 irq vec%0d", i), 32'(irq), 32'(VEC[i][0]));
      if (limit >= 5'd16) chk($sformatf("R8 vec%0d", i), 32'(raw[0]), 0);
      @(negedge clk);
    end
    level = '0; limit = '0; sgate = 0; smask = 0; ext = 0;

    // R3 empty-read event, masked off
    evt = 2'b01; step(); evt = '0;
    chk("R3 err set by empty read", 32'(raw[1]), 1);
    chk("R6 err masked off", 32'(msk[1]), 0);
    chk("R6 irq with err masked", 32'(irq), 0);
    emask = 1'b1; #1;
    chk("R6 err masked on", 32'(msk[1]), 1);
    chk("R7 irq from err", 32'(irq), 1);
    // R4 sticky
    repeat (3) step();
    chk("R4 err sticky", 32'(raw[1]), 1);
    // R4 clear
    eclr = 1'b1; step(); eclr = 1'b0;
    chk("R4 err cleared raw", 32'(raw[1]), 0);
    chk("R4 err cleared masked", 32'(msk[1]), 0);
    chk("R4 irq drops", 32'(irq), 0);
    // R3 stereo order event
    evt = 2'b10; step(); evt = '0;
    chk("R3 err set by order event", 32'(raw[1]), 1);
    // R5 collision
    evt = 2'b01; eclr = 1'b1; step(); evt = '0; eclr = 1'b0;
    chk("R5 event beats clear", 32'(raw[1]), 1);
    step();
    chk("R5 still set", 32'(raw[1]), 1);
    eclr = 1'b1; step(); eclr = 1'b0;
    chk("R4 clear after collision", 32'(raw[1]), 0);
    // R1 not sticky
    sgate = 1; smask = 1; level = 5'd9; limit = 5'd2; #1;
    chk("R1 sreq on", 32'(raw[0]), 1);
    step(); level = 5'd2; #1;
    chk("R1 sreq drops with level", 32'(raw[0]), 0);
    // R9 reset clears error
    evt = 2'b11; step(); evt = '0;
    rst_n = 1'b0; #1;
    chk("R9 reset clears err", 32'(raw[1]), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule